// File: doc/BRIEF.md
# SPI Clock and Chip-Select Timing Generator

This block produces the serial clock and the chip-select line for an SPI host, along with the strobes that tell a separate data shifter when to shift and when to capture. Every interval is set by its own count field. These fields are the clock high time, the clock low time, the select-to-first-edge setup, the last-edge-to-release hold and the minimum inactive gap before the next transfer. Each interval lasts its count plus one core cycles, so a count of zero still gives one cycle.

A transfer begins when `start` is seen while `ready_o` is high and the byte count is non-zero. At that moment the block copies every configuration field into its own registers. The transfer then runs eight clock periods per byte. The host can end it early with `stop`, which takes effect at the next byte boundary. `done_o` pulses once, in the cycle where chip select releases.

Clock polarity sets the idle level. Clock phase decides whether capture happens on the leading or the trailing edge of each period. A sample-select bit swaps the capture edge, and a small delay field pushes the capture strobe later by whole core cycles. A soft reset forces the lines to idle on the next edge.

Top module: `spi_timing_gen`

## Requirements
- R1: With clock polarity 0, the clock stays high for high-count+1 cycles and low for low-count+1 cycles of each period; with polarity 1 the leading (low) level uses the low count and the trailing (high) level uses the high count.
- R2: Chip select turns active in the cycle after `start` is accepted, and it stays active for setup-count+1 cycles before the first clock edge.
- R3: After the last clock edge of a transfer, chip select stays active for hold-count+1 cycles and then releases; `done_o` is high for exactly that release cycle.
- R4: Chip select stays inactive for idle-count+1 cycles after release. `ready_o` rises in the last of those cycles, and a `start` accepted in that cycle begins the next transfer with no extra gap.
- R5: In idle the clock sits at the polarity level. With phase 0, `sample_o` (at zero delay) comes on leading edges and `shift_o` on trailing edges; with phase 1 these are swapped. Each strobe is high in the same cycle as the clock transition it marks.
- R6: With the chip-select polarity bit set, the active level of `cs_o` is 1; with it clear, the active level is 0.
- R7: The sample-select bit moves `sample_o` to the opposite edge of each period and leaves `shift_o` unchanged.
- R8: The 3-bit delay field D makes `sample_o` appear D cycles after the edge it belongs to.
- R9: A transfer runs `nbytes`×8 clock periods. A `start` with `nbytes` equal to 0 is ignored.
- R10: A `start` that arrives while `ready_o` is low has no effect on the transfer in progress.
- R11: `stop` during a transfer ends it after the byte in progress. A stop that arrives before the first clock edge still lets one full byte run.
- R12: Configuration is copied only when a transfer is accepted. Changes made during a transfer do not affect it, and they apply from the next start.
- R13: `soft_rst` returns the clock to the idle level, releases chip select and clears all strobes, including delayed sample strobes, on the next edge; `ready_o` is then high.
- R14: After reset the clock is at the idle level, chip select is inactive, no strobe or `done_o` is active and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous abort to idle |
| start | input | 1 | Request a transfer |
| stop | input | 1 | End the transfer at the next byte boundary |
| nbytes | input | 16 | Byte count for the requested transfer |
| cfg_sck_hi | input | 16 | Clock high time minus one |
| cfg_sck_lo | input | 16 | Clock low time minus one |
| cfg_cs_setup | input | 16 | Select-to-first-edge time minus one |
| cfg_cs_hold | input | 16 | Last-edge-to-release time minus one |
| cfg_cs_idle | input | 8 | Inactive gap minus one |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0: capture on the leading edge, 1: capture on the trailing edge |
| cfg_cs_high | input | 1 | 1: chip select active-high |
| cfg_samp_opp | input | 1 | Move capture to the opposite edge |
| cfg_tick | input | 3 | Extra capture delay in core cycles |
| sck_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| shift_o | output | 1 | Shift strobe to the data path |
| sample_o | output | 1 | Capture strobe to the data path |
| done_o | output | 1 | One-cycle pulse when chip select releases |
| ready_o | output | 1 | A start is accepted in this cycle |

## Verification
All outputs are registered, so every effect of an input sampled at an edge becomes visible in the cycle after that edge. For a transfer accepted at edge P, the expected value for the cycle after edge P+i is entry i of a per-cycle list. The list holds setup, lead and trail levels, hold, gap and tail cycles, all counted from the count fields. The capture strobe in that list is moved D entries later, and any entry at or after a soft reset is forced to idle. The driver queues the whole list when it raises `start`. It places `stop`, `soft_rst`, a stray `start` or a configuration change at chosen entry numbers. The monitor pops one entry two nanoseconds after every rising edge, so each comparison lands on the cycle the result is due.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LEAD,
    ST_TRAIL,
    ST_HOLD,
    ST_GAP
  } tg_state_e;

endpackage

// File: rtl/spi_tg_cfg_latch.sv
module spi_tg_cfg_latch #(
  parameter int CW = 16,
  parameter int IW = 8,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hold_i,
  input  logic [IW-1:0] idle_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          cs_high_i,
  input  logic          samp_opp_i,
  input  logic [DW-1:0] tick_i,
  output logic [CW-1:0] hi_q,
  output logic [CW-1:0] lo_q,
  output logic [CW-1:0] hold_q,
  output logic [IW-1:0] idle_q,
  output logic          cpol_q,
  output logic          cpha_q,
  output logic          cs_high_q,
  output logic          samp_opp_q,
  output logic [DW-1:0] tick_q
);

  // Snapshot taken only when a transfer is accepted.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q       <= '0;
      lo_q       <= '0;
      hold_q     <= '0;
      idle_q     <= '0;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      cs_high_q  <= 1'b0;
      samp_opp_q <= 1'b0;
      tick_q     <= '0;
    end else if (load) begin
      hi_q       <= hi_i;
      lo_q       <= lo_i;
      hold_q     <= hold_i;
      idle_q     <= idle_i;
      cpol_q     <= cpol_i;
      cpha_q     <= cpha_i;
      cs_high_q  <= cs_high_i;
      samp_opp_q <= samp_opp_i;
      tick_q     <= tick_i;
    end
  end

endmodule

// File: rtl/spi_tg_sample_dly.sv
module spi_tg_sample_dly #(
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [DW-1:0] tick,
  input  logic          din,
  output logic          dout
);

  localparam int DEPTH = (1 << DW) - 1;

  logic taps [0:DEPTH];

  assign taps[0] = din;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (clr) taps[k] <= 1'b0;
      else     taps[k] <= taps[k-1];
    end
  end

  assign dout = taps[tick];

  // R8: a delay of one cycle reproduces the undelayed strobe one cycle later
  a_r8_one_tick_delay: assert property (@(posedge clk) disable iff (clr)
    (!$past(clr) && tick == DW'(1) && $past(tick) == DW'(1)) |-> (dout == $past(din)));

endmodule

// File: rtl/spi_tg_seq.sv
module spi_tg_seq
  import spi_tg_pkg::*;
#(
  parameter int CW = 16,
  parameter int IW = 8,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          start,
  input  logic          stop,
  input  logic [LW-1:0] nbytes,
  input  logic          live_cpol,
  input  logic          live_cs_high,
  input  logic [CW-1:0] live_setup,
  input  logic [CW-1:0] hi_q,
  input  logic [CW-1:0] lo_q,
  input  logic [CW-1:0] hold_q,
  input  logic [IW-1:0] idle_q,
  input  logic          cpol_q,
  input  logic          cpha_q,
  input  logic          cs_high_q,
  input  logic          samp_opp_q,
  output logic          accept_o,
  output logic          sck_o,
  output logic          cs_o,
  output logic          shift_o,
  output logic          samp_raw_o,
  output logic          done_o,
  output logic          ready_o
);

  localparam int BW = LW + 3;

  tg_state_e     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bits_left;
  logic [BW-1:0] bits_nx;
  logic          stop_pend;
  logic          sck_q, cs_q, sh_q, sa_q, done_q;
  logic [CW-1:0] lead_n, trail_n;
  logic          samp_on_trail, shift_on_trail;
  logic          cnt_zero, ready;

  assign cnt_zero       = (cnt == '0);
  assign ready          = (st == ST_IDLE) || (st == ST_GAP && cnt_zero);
  assign accept_o       = start && (nbytes != '0) && ready;
  assign lead_n         = cpol_q ? lo_q : hi_q;
  assign trail_n        = cpol_q ? hi_q : lo_q;
  assign samp_on_trail  = cpha_q ^ samp_opp_q;
  assign shift_on_trail = ~cpha_q;
  assign bits_nx        = bits_left - BW'(1);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      bits_left <= '0;
      stop_pend <= 1'b0;
      sck_q     <= live_cpol;
      cs_q      <= ~live_cs_high;
      sh_q      <= 1'b0;
      sa_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      sh_q   <= 1'b0;
      sa_q   <= 1'b0;
      done_q <= 1'b0;
      if (stop && st != ST_IDLE) stop_pend <= 1'b1;
      if (accept_o) begin
        st        <= ST_SETUP;
        cnt       <= live_setup;
        bits_left <= {nbytes, 3'b000};
        stop_pend <= 1'b0;
        sck_q     <= live_cpol;
        cs_q      <= live_cs_high;
      end else begin
        unique case (st)
          ST_IDLE: begin
            sck_q <= live_cpol;
            cs_q  <= ~live_cs_high;
          end
          ST_SETUP: begin
            if (cnt_zero) begin
              st    <= ST_LEAD;
              cnt   <= lead_n;
              sck_q <= ~cpol_q;
              sh_q  <= ~shift_on_trail;
              sa_q  <= ~samp_on_trail;
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
          ST_LEAD: begin
            if (cnt_zero) begin
              sck_q     <= cpol_q;
              sh_q      <= shift_on_trail;
              sa_q      <= samp_on_trail;
              bits_left <= bits_nx;
              if (bits_nx == '0 || (stop_pend && bits_nx[2:0] == 3'd0)) begin
                st  <= ST_HOLD;
                cnt <= hold_q;
              end else begin
                st  <= ST_TRAIL;
                cnt <= trail_n;
              end
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
          ST_TRAIL: begin
            if (cnt_zero) begin
              st    <= ST_LEAD;
              cnt   <= lead_n;
              sck_q <= ~cpol_q;
              sh_q  <= ~shift_on_trail;
              sa_q  <= ~samp_on_trail;
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
          ST_HOLD: begin
            if (cnt_zero) begin
              st     <= ST_GAP;
              cnt    <= CW'(idle_q);
              cs_q   <= ~cs_high_q;
              done_q <= 1'b1;
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
          ST_GAP: begin
            if (cnt_zero) st <= ST_IDLE;
            else          cnt <= cnt - CW'(1);
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign sck_o      = sck_q;
  assign cs_o       = cs_q;
  assign shift_o    = sh_q;
  assign samp_raw_o = sa_q;
  assign done_o     = done_q;
  assign ready_o    = ready;

  // R5: every strobe coincides with a transition of the serial clock
  a_r5_strobe_on_edge: assert property (@(posedge clk) disable iff (rst)
    (sh_q || sa_q) |-> (sck_q != $past(sck_q)));

  // R6: clock leaves its idle level only while chip select is active
  a_r6_sck_inside_cs: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && sck_q != cpol_q) |-> (cs_q == cs_high_q));

  // R3: done marks the cycle in which chip select releases
  a_r3_done_at_release: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (cs_q != cs_high_q && $past(cs_q) == cs_high_q));

  // R13: soft reset idles both lines on the next edge
  a_r13_soft_idle: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (sck_q == $past(live_cpol) && cs_q != $past(live_cs_high) && !sh_q && !sa_q));

  // R9: clock periods run only while bits remain
  a_r9_bits_left: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LEAD) |-> (bits_left != '0));

endmodule

// File: rtl/spi_timing_gen.sv
module spi_timing_gen #(
  parameter int CW = 16,
  parameter int IW = 8,
  parameter int LW = 16,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          start,
  input  logic          stop,
  input  logic [LW-1:0] nbytes,
  input  logic [CW-1:0] cfg_sck_hi,
  input  logic [CW-1:0] cfg_sck_lo,
  input  logic [CW-1:0] cfg_cs_setup,
  input  logic [CW-1:0] cfg_cs_hold,
  input  logic [IW-1:0] cfg_cs_idle,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          cfg_cs_high,
  input  logic          cfg_samp_opp,
  input  logic [DW-1:0] cfg_tick,
  output logic          sck_o,
  output logic          cs_o,
  output logic          shift_o,
  output logic          sample_o,
  output logic          done_o,
  output logic          ready_o
);

  logic          accept;
  logic [CW-1:0] hi_q, lo_q, hold_q;
  logic [IW-1:0] idle_q;
  logic          cpol_q, cpha_q, cs_high_q, samp_opp_q;
  logic [DW-1:0] tick_q;
  logic          samp_raw;
  logic          dly_clr;

  assign dly_clr = rst | soft_rst;

  spi_tg_cfg_latch #(.CW(CW), .IW(IW), .DW(DW)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .hi_i       (cfg_sck_hi),
    .lo_i       (cfg_sck_lo),
    .hold_i     (cfg_cs_hold),
    .idle_i     (cfg_cs_idle),
    .cpol_i     (cfg_cpol),
    .cpha_i     (cfg_cpha),
    .cs_high_i  (cfg_cs_high),
    .samp_opp_i (cfg_samp_opp),
    .tick_i     (cfg_tick),
    .hi_q       (hi_q),
    .lo_q       (lo_q),
    .hold_q     (hold_q),
    .idle_q     (idle_q),
    .cpol_q     (cpol_q),
    .cpha_q     (cpha_q),
    .cs_high_q  (cs_high_q),
    .samp_opp_q (samp_opp_q),
    .tick_q     (tick_q)
  );

  spi_tg_seq #(.CW(CW), .IW(IW), .LW(LW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .soft_rst     (soft_rst),
    .start        (start),
    .stop         (stop),
    .nbytes       (nbytes),
    .live_cpol    (cfg_cpol),
    .live_cs_high (cfg_cs_high),
    .live_setup   (cfg_cs_setup),
    .hi_q         (hi_q),
    .lo_q         (lo_q),
    .hold_q       (hold_q),
    .idle_q       (idle_q),
    .cpol_q       (cpol_q),
    .cpha_q       (cpha_q),
    .cs_high_q    (cs_high_q),
    .samp_opp_q   (samp_opp_q),
    .accept_o     (accept),
    .sck_o        (sck_o),
    .cs_o         (cs_o),
    .shift_o      (shift_o),
    .samp_raw_o   (samp_raw),
    .done_o       (done_o),
    .ready_o      (ready_o)
  );

  spi_tg_sample_dly #(.DW(DW)) u_dly (
    .clk  (clk),
    .clr  (dly_clr),
    .tick (tick_q),
    .din  (samp_raw),
    .dout (sample_o)
  );

endmodule

// File: tb/spi_timing_gen_bench.sv
module spi_timing_gen_bench;
  localparam int CW = 16;
  localparam int IW = 8;
  localparam int LW = 16;
  localparam int DW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, soft_rst, start, stop;
  logic [LW-1:0] nbytes;
  logic [CW-1:0] cfg_sck_hi, cfg_sck_lo, cfg_cs_setup, cfg_cs_hold;
  logic [IW-1:0] cfg_cs_idle;
  logic          cfg_cpol, cfg_cpha, cfg_cs_high, cfg_samp_opp;
  logic [DW-1:0] cfg_tick;
  logic          sck_o, cs_o, shift_o, sample_o, done_o, ready_o;

  spi_timing_gen #(.CW(CW), .IW(IW), .LW(LW), .DW(DW)) u_spi_timing_gen (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .start(start), .stop(stop),
    .nbytes(nbytes), .cfg_sck_hi(cfg_sck_hi), .cfg_sck_lo(cfg_sck_lo),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_hold(cfg_cs_hold),
    .cfg_cs_idle(cfg_cs_idle), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_cs_high(cfg_cs_high), .cfg_samp_opp(cfg_samp_opp), .cfg_tick(cfg_tick),
    .sck_o(sck_o), .cs_o(cs_o), .shift_o(shift_o), .sample_o(sample_o),
    .done_o(done_o), .ready_o(ready_o)
  );

  // expected vector bits: sck cs shift sample done ready
  logic [5:0] q_exp [$];
  string      q_tag [$];
  int n_chk = 0;
  int n_bad = 0;

  logic [5:0] v   [0:1023];
  logic       sar [0:1023];
  int         vlen;

  function automatic logic [5:0] observed();
    return {sck_o, cs_o, shift_o, sample_o, done_o, ready_o};
  endfunction

  // monitor: one scoreboard entry per cycle, 2 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        logic [5:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        n_chk++;
        if (observed() !== e) begin
          n_bad++;
          $display("FAIL %s: actual=%b expected=%b (sck cs shift sample done ready) t=%0t",
                   t, observed(), e, $time);
        end
      end
    end
  end

  task automatic put(input logic s, input logic c, input logic sh, input logic sa,
                     input logic dn, input logic rdy);
    v[vlen]   = {s, c, sh, 1'b0, dn, rdy};
    sar[vlen] = sa;
    vlen++;
  endtask

  // expected per-cycle waveform built from the count fields
  task automatic build(input int nbe, input int tail, output int lg);
    logic act, ina, st_tr, sh_tr;
    int ln, tn, nbits;
    act   = cfg_cs_high;
    ina   = ~cfg_cs_high;
    ln    = cfg_cpol ? int'(cfg_sck_lo) : int'(cfg_sck_hi);
    tn    = cfg_cpol ? int'(cfg_sck_hi) : int'(cfg_sck_lo);
    st_tr = cfg_cpha ^ cfg_samp_opp;
    sh_tr = ~cfg_cpha;
    nbits = nbe * 8;
    vlen  = 0;
    for (int j = 0; j <= int'(cfg_cs_setup); j++) put(cfg_cpol, act, 0, 0, 0, 0);
    for (int b = 0; b < nbits; b++) begin
      int tl;
      for (int j = 0; j <= ln; j++)
        put(~cfg_cpol, act, (j == 0) && !sh_tr, (j == 0) && !st_tr, 0, 0);
      tl = (b == nbits - 1) ? int'(cfg_cs_hold) : tn;
      for (int j = 0; j <= tl; j++)
        put(cfg_cpol, act, (j == 0) && sh_tr, (j == 0) && st_tr, 0, 0);
    end
    for (int j = 0; j <= int'(cfg_cs_idle); j++)
      put(cfg_cpol, ina, 0, 0, j == 0, j == int'(cfg_cs_idle));
    lg = vlen - 1;
    for (int j = 0; j < tail; j++) put(cfg_cpol, ina, 0, 0, 0, 1);
    for (int i = 0; i < vlen; i++)
      v[i][2] = (i >= int'(cfg_tick)) ? sar[i - int'(cfg_tick)] : 1'b0;
  endtask

  // caller is at a falling edge; returns at the falling edge of the last gap cycle
  task automatic xfer(input int nb, input int stop_at, input int sr_at, input int poke_at,
                      input int chg_at, input int tail, input string tag);
    int nbe, lg, ret;
    start  = 1'b1;
    nbytes = LW'(nb);
    nbe    = (stop_at >= 0) ? 1 : nb;
    build(nbe, tail, lg);
    ret = lg;
    if (sr_at >= 0) begin
      for (int i = sr_at; i < sr_at + tail; i++) v[i] = {cfg_cpol, ~cfg_cs_high, 4'b0001};
      vlen = sr_at + tail;
      ret  = sr_at;
    end
    for (int i = 0; i < vlen; i++) begin
      q_exp.push_back(v[i]);
      q_tag.push_back(tag);
    end
    for (int c = 0; c <= ret; c++) begin
      @(negedge clk);
      start    = (c == poke_at);
      nbytes   = (c == poke_at) ? LW'(3) : LW'(nb);
      stop     = (c == stop_at);
      soft_rst = (sr_at >= 0) && (c == sr_at - 1);
      if (c == chg_at) cfg_sck_hi = cfg_sck_hi + CW'(5);
    end
    start    = 1'b0;
    stop     = 1'b0;
    soft_rst = 1'b0;
  endtask

  task automatic drain();
    while (q_exp.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all R): actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; soft_rst = 1'b0; start = 1'b0; stop = 1'b0; nbytes = '0;
    cfg_sck_hi = 16'd1; cfg_sck_lo = 16'd2; cfg_cs_setup = 16'd2; cfg_cs_hold = 16'd1;
    cfg_cs_idle = 8'd3; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_cs_high = 1'b0;
    cfg_samp_opp = 1'b0; cfg_tick = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R14: idle levels after reset (sck 0, cs inactive 1, ready 1)
    n_chk++;
    if (observed() !== 6'b010001) begin
      n_bad++;
      $display("FAIL R14: actual=%b expected=%b", observed(), 6'b010001);
    end

    // base transfer, polarity 0, phase 0
    xfer(1, -1, -1, -1, -1, 2, "R1 R2 R3 R4 R5 R9");
    drain();

    // polarity 1, phase 1, active-high select, zero counts
    cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_cs_high = 1'b1;
    cfg_sck_hi = 16'd0; cfg_sck_lo = 16'd3; cfg_cs_setup = 16'd0;
    cfg_cs_hold = 16'd0; cfg_cs_idle = 8'd0;
    repeat (2) @(negedge clk);
    xfer(2, -1, -1, -1, -1, 2, "R1 R5 R6 R9");
    drain();

    // opposite capture edge plus delay 3
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_cs_high = 1'b0; cfg_samp_opp = 1'b1;
    cfg_tick = 3'd3; cfg_sck_hi = 16'd1; cfg_sck_lo = 16'd1; cfg_cs_setup = 16'd1;
    cfg_cs_hold = 16'd2; cfg_cs_idle = 8'd1;
    repeat (2) @(negedge clk);
    xfer(1, -1, -1, -1, -1, 8, "R7 R8");
    drain();

    // phase 1 with opposite edge (capture back on leading), maximum delay
    cfg_cpha = 1'b1; cfg_tick = 3'd7;
    repeat (2) @(negedge clk);
    xfer(1, -1, -1, -1, -1, 8, "R7 R8");
    drain();

    // zero byte count: nothing happens
    cfg_cpha = 1'b0; cfg_samp_opp = 1'b0; cfg_tick = '0;
    repeat (2) @(negedge clk);
    start = 1'b1; nbytes = '0;
    for (int i = 0; i < 4; i++) begin
      q_exp.push_back(6'b010001);
      q_tag.push_back("R9 zero count");
    end
    @(negedge clk);
    start = 1'b0;
    drain();

    // stray start mid-transfer
    xfer(1, -1, -1, 4, -1, 2, "R10");
    drain();

    // stop before the first edge of a two-byte transfer
    xfer(2, 0, -1, -1, -1, 2, "R11");
    drain();

    // high count changed mid-transfer, then used by the next one
    xfer(1, -1, -1, -1, 3, 2, "R12 old");
    drain();
    xfer(1, -1, -1, -1, -1, 2, "R12 new");
    drain();

    // back-to-back: second start in the last gap cycle
    cfg_sck_hi = 16'd1; cfg_cs_idle = 8'd2;
    repeat (2) @(negedge clk);
    xfer(1, -1, -1, -1, -1, 0, "R4 first");
    xfer(1, -1, -1, -1, -1, 2, "R4 second");
    drain();

    // soft reset mid-transfer, with a delayed capture in flight
    cfg_tick = 3'd2;
    repeat (2) @(negedge clk);
    xfer(1, -1, 6, -1, -1, 4, "R13");
    drain();

    summary();
    $finish;
  end

endmodule